// File: doc/BRIEF.md
# Graphic LCD Controller Host Command Port

This block sits between an 8-bit microcontroller bus and the internals of a dot-matrix graphic LCD controller. The host selects the block with an active-low chip select. It chooses a direction with a read/write line and picks either the command register or the parameter/data register with a register-select line. Transfers are framed by an enable strobe. A command write picks a target. The next parameter write fills that target's register, sends a one-cycle load pulse to the timing and address blocks, and raises a busy flag for a fixed execution time.

Two targets do not end in a local register. Cursor address bytes go to the cursor counter over a valid/ready handshake. `cur_valid` stays high, and `cur_hi`/`cur_data` stay stable, until `cur_ready` is seen high at a clock edge. Busy stays set until that transfer completes. Memory reads use a one-byte prefetch buffer. Each data read returns the buffer and then starts a fetch over a second valid/ready request channel (`fetch_valid`/`fetch_ready`), whose answer comes back on `fetch_rsp_valid`. So the first data read after the read command returns stale data. All host signals are taken as synchronous to `clk`.

Top module: `lcd_host_if`

## Requirements
- R1: With `host_cs_n` high, no strobe has any effect on registers, load pulses or the bus drive. With `host_rw` = 1 the host reads, with 0 it writes. `host_rs` = 1 addresses the command register and 0 the parameter/data register.
- R2: A write takes effect at the clock edge that sees `host_en` fall. The matching load pulse is high for exactly the following cycle.
- R3: `host_doe` is high only while `host_en` is high with `host_cs_n` low and `host_rw` high. It is low during writes and whenever the strobe is low.
- R4: The command register keeps only bus bits 3:0. The codes are: 0 mode, 1 pitch, 2 character count, 3 time divisions, 4 cursor row, 8 start address low byte, 9 start address high byte, 10 cursor address low byte, 11 cursor address high byte, 13 memory read.
- R5: A read with `host_rs` = 1 returns the busy flag on bit 7 and zeros on bits 6:0.
- R6: An accepted parameter write keeps busy high for BUSY_CYCLES cycles. While busy is high, both command writes and parameter writes are ignored.
- R7: The mode byte keeps bits 5:0. Bit 5 is display on, bit 4 is master (1) or slave (0), bits 3:2 are the cursor mode (00 off, 01 on, 10 off with character blink, 11 blinking), bit 1 is graphic (1) or character (0), and bit 0 is external (1) or internal (0) character generator.
- R8: The pitch byte takes vertical pitch minus one from bits 7:4 and horizontal pitch code from bits 2:0. A horizontal code below 5 makes the whole write ignored: no register change, no load pulse and no busy.
- R9: After `rst_n` low, display is off, mode is slave, the horizontal pitch code is 5, all other fields and the read buffer are zero, busy is low and no handshake is valid.
- R10: The character count and time divisions keep bits 6:0 and the cursor row keeps bits 3:0. The start address low and high bytes form a 16-bit address, and either byte pulses `ld_start`.
- R11: Codes 10 and 11 present the byte on `cur_data` with `cur_hi` = 0 or 1. `cur_valid` and the data are held stable until `cur_ready`, and busy stays high while the transfer is pending.
- R12: With command 13 active, a data read returns the buffer and then requests a fetch. The answer is loaded into the buffer, so the first read returns stale data. Busy stays high until the answer arrives.
- R13: A parameter write under any code not listed in R4, or under code 13, changes nothing and does not set busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_cs_n | input | 1 | Chip select, active low |
| host_rw | input | 1 | 1 = host reads, 0 = host writes |
| host_rs | input | 1 | 1 = command/status, 0 = parameter/data |
| host_en | input | 1 | Transfer strobe |
| host_din | input | 8 | Bus data from host |
| host_dout | output | 8 | Bus data to host |
| host_doe | output | 1 | Bus drive enable (tri-state control) |
| disp_on | output | 1 | Display enable |
| master_sel | output | 1 | Master (1) / slave (0) |
| cursor_mode | output | 2 | Cursor mode code |
| graphic_sel | output | 1 | Graphic (1) / character (0) mode |
| ext_cg_sel | output | 1 | External character generator select |
| pitch_v | output | 4 | Vertical pitch minus one |
| pitch_h | output | 3 | Horizontal pitch code |
| char_cnt | output | 7 | Characters per line minus one |
| time_div | output | 7 | Time divisions minus one |
| cursor_row | output | 4 | Cursor row minus one |
| start_addr | output | 16 | Display start address |
| ld_mode | output | 1 | Mode load pulse |
| ld_pitch | output | 1 | Pitch load pulse |
| ld_cnt | output | 1 | Character count load pulse |
| ld_div | output | 1 | Time division load pulse |
| ld_row | output | 1 | Cursor row load pulse |
| ld_start | output | 1 | Start address load pulse |
| cur_valid | output | 1 | Cursor byte valid |
| cur_ready | input | 1 | Cursor counter accepts byte |
| cur_hi | output | 1 | Cursor byte is high half |
| cur_data | output | 8 | Cursor address byte |
| fetch_valid | output | 1 | Memory fetch request |
| fetch_ready | input | 1 | Fetch request accepted |
| fetch_rsp_valid | input | 1 | Fetch answer valid |
| fetch_rsp_data | input | 8 | Fetch answer byte |

## Verification
The assertions assume a well-behaved host. It holds `host_cs_n`, `host_rw`, `host_rs` and `host_din` steady across every strobe edge. It returns `fetch_rsp_valid` only for a fetch it has accepted. It never raises `cur_ready` or `fetch_ready` outside the block's control. The bench drives every bus signal at the falling clock edge and changes select and data only while the strobe is low. Its memory model answers exactly one cycle after each accepted fetch. Busy is polled through status reads before each new command, except in the tests that write into a busy window on purpose.

// File: rtl/lcd_host_pkg.sv
package lcd_host_pkg;

  typedef enum logic [3:0] {
    CMD_MODE     = 4'h0,
    CMD_PITCH    = 4'h1,
    CMD_HCOUNT   = 4'h2,
    CMD_TDIV     = 4'h3,
    CMD_CROW     = 4'h4,
    CMD_START_LO = 4'h8,
    CMD_START_HI = 4'h9,
    CMD_CUR_LO   = 4'hA,
    CMD_CUR_HI   = 4'hB,
    CMD_MEM_RD   = 4'hD
  } cmd_e;

  localparam logic [2:0] HPITCH_MIN  = 3'd5;
  localparam logic [2:0] HPITCH_RST  = 3'd5;

  typedef enum logic [1:0] {
    FT_IDLE = 2'd0,
    FT_REQ  = 2'd1,
    FT_WAIT = 2'd2
  } fetch_st_e;

endpackage

// File: rtl/hostif_bus_decode.sv
module hostif_bus_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rw,
  input  logic rs,
  input  logic en,
  output logic ev_cmd_wr,
  output logic ev_par_wr,
  output logic ev_dat_rd,
  output logic drive_en,
  output logic sel_status
);

  logic en_q;
  logic en_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en;
  end

  assign en_fall    = en_q & ~en;
  assign ev_cmd_wr  = en_fall & ~cs_n & ~rw &  rs;
  assign ev_par_wr  = en_fall & ~cs_n & ~rw & ~rs;
  assign ev_dat_rd  = en_fall & ~cs_n &  rw & ~rs;
  assign drive_en   = en & ~cs_n & rw;
  assign sel_status = rs;

endmodule

// File: rtl/hostif_busy_timer.sv
module hostif_busy_timer #(
  parameter int unsigned CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy_t
);

  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOADV = CW'(CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (start)       cnt <= LOADV;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy_t = (cnt != '0);

endmodule

// File: rtl/hostif_param_bank.sv
module hostif_param_bank
  import lcd_host_pkg::*;
#(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [3:0]       code,
  input  logic [7:0]       din,
  output logic             took,
  output logic [5:0]       mode,
  output logic [3:0]       pitch_v,
  output logic [2:0]       pitch_h,
  output logic [CNT_W-1:0] char_cnt,
  output logic [CNT_W-1:0] time_div,
  output logic [ROW_W-1:0] cursor_row,
  output logic [15:0]      start_addr,
  output logic             ld_mode,
  output logic             ld_pitch,
  output logic             ld_cnt,
  output logic             ld_div,
  output logic             ld_row,
  output logic             ld_start,
  output logic             cur_valid,
  input  logic             cur_ready,
  output logic             cur_hi,
  output logic [7:0]       cur_data,
  output logic             cur_pend
);

  logic code_ok;

  always_comb begin
    unique case (code)
      CMD_MODE, CMD_HCOUNT, CMD_TDIV, CMD_CROW,
      CMD_START_LO, CMD_START_HI, CMD_CUR_LO, CMD_CUR_HI: code_ok = 1'b1;
      CMD_PITCH: code_ok = (din[2:0] >= HPITCH_MIN);
      default:   code_ok = 1'b0;
    endcase
  end

  assign took = wr & code_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= '0;
      pitch_v    <= '0;
      pitch_h    <= HPITCH_RST;
      char_cnt   <= '0;
      time_div   <= '0;
      cursor_row <= '0;
      start_addr <= '0;
      ld_mode    <= 1'b0;
      ld_pitch   <= 1'b0;
      ld_cnt     <= 1'b0;
      ld_div     <= 1'b0;
      ld_row     <= 1'b0;
      ld_start   <= 1'b0;
    end else begin
      ld_mode  <= 1'b0;
      ld_pitch <= 1'b0;
      ld_cnt   <= 1'b0;
      ld_div   <= 1'b0;
      ld_row   <= 1'b0;
      ld_start <= 1'b0;
      if (took) begin
        unique case (code)
          CMD_MODE: begin
            mode    <= din[5:0];
            ld_mode <= 1'b1;
          end
          CMD_PITCH: begin
            pitch_v  <= din[7:4];
            pitch_h  <= din[2:0];
            ld_pitch <= 1'b1;
          end
          CMD_HCOUNT: begin
            char_cnt <= din[CNT_W-1:0];
            ld_cnt   <= 1'b1;
          end
          CMD_TDIV: begin
            time_div <= din[CNT_W-1:0];
            ld_div   <= 1'b1;
          end
          CMD_CROW: begin
            cursor_row <= din[ROW_W-1:0];
            ld_row     <= 1'b1;
          end
          CMD_START_LO: begin
            start_addr[7:0] <= din;
            ld_start        <= 1'b1;
          end
          CMD_START_HI: begin
            start_addr[15:8] <= din;
            ld_start         <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // cursor byte handshake toward the cursor counter
  logic cur_go;
  assign cur_go = took & ((code == CMD_CUR_LO) | (code == CMD_CUR_HI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_valid <= 1'b0;
      cur_hi    <= 1'b0;
      cur_data  <= '0;
    end else if (cur_go) begin
      cur_valid <= 1'b1;
      cur_hi    <= (code == CMD_CUR_HI);
      cur_data  <= din;
    end else if (cur_valid && cur_ready) begin
      cur_valid <= 1'b0;
    end
  end

  assign cur_pend = cur_valid;

endmodule

// File: rtl/hostif_fetch.sv
module hostif_fetch
  import lcd_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig,
  output logic       fetch_valid,
  input  logic       fetch_ready,
  input  logic       rsp_valid,
  input  logic [7:0] rsp_data,
  output logic [7:0] rdbuf,
  output logic       pend
);

  fetch_st_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= FT_IDLE;
      rdbuf <= '0;
    end else begin
      unique case (st)
        FT_IDLE: if (trig) st <= FT_REQ;
        FT_REQ:  if (fetch_ready) st <= FT_WAIT;
        FT_WAIT: if (rsp_valid) begin
          rdbuf <= rsp_data;
          st    <= FT_IDLE;
        end
        default: st <= FT_IDLE;
      endcase
    end
  end

  assign fetch_valid = (st == FT_REQ);
  assign pend        = (st != FT_IDLE);

endmodule

// File: rtl/lcd_host_if.sv
module lcd_host_if
  import lcd_host_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 200,
  parameter int unsigned CNT_W       = 7,
  parameter int unsigned ROW_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_cs_n,
  input  logic             host_rw,
  input  logic             host_rs,
  input  logic             host_en,
  input  logic [7:0]       host_din,
  output logic [7:0]       host_dout,
  output logic             host_doe,
  output logic             disp_on,
  output logic             master_sel,
  output logic [1:0]       cursor_mode,
  output logic             graphic_sel,
  output logic             ext_cg_sel,
  output logic [3:0]       pitch_v,
  output logic [2:0]       pitch_h,
  output logic [CNT_W-1:0] char_cnt,
  output logic [CNT_W-1:0] time_div,
  output logic [ROW_W-1:0] cursor_row,
  output logic [15:0]      start_addr,
  output logic             ld_mode,
  output logic             ld_pitch,
  output logic             ld_cnt,
  output logic             ld_div,
  output logic             ld_row,
  output logic             ld_start,
  output logic             cur_valid,
  input  logic             cur_ready,
  output logic             cur_hi,
  output logic [7:0]       cur_data,
  output logic             fetch_valid,
  input  logic             fetch_ready,
  input  logic             fetch_rsp_valid,
  input  logic [7:0]       fetch_rsp_data
);

  logic       ev_cmd_wr, ev_par_wr, ev_dat_rd, sel_status;
  logic       busy, busy_t, cur_pend, fetch_pend, took;
  logic [3:0] cmd_q;
  logic [5:0] mode;
  logic [7:0] rdbuf;

  hostif_bus_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (host_cs_n),
    .rw         (host_rw),
    .rs         (host_rs),
    .en         (host_en),
    .ev_cmd_wr  (ev_cmd_wr),
    .ev_par_wr  (ev_par_wr),
    .ev_dat_rd  (ev_dat_rd),
    .drive_en   (host_doe),
    .sel_status (sel_status)
  );

  assign busy = busy_t | cur_pend | fetch_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cmd_q <= CMD_MODE;
    else if (ev_cmd_wr && !busy) cmd_q <= host_din[3:0];
  end

  hostif_param_bank #(.CNT_W(CNT_W), .ROW_W(ROW_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (ev_par_wr & ~busy),
    .code       (cmd_q),
    .din        (host_din),
    .took       (took),
    .mode       (mode),
    .pitch_v    (pitch_v),
    .pitch_h    (pitch_h),
    .char_cnt   (char_cnt),
    .time_div   (time_div),
    .cursor_row (cursor_row),
    .start_addr (start_addr),
    .ld_mode    (ld_mode),
    .ld_pitch   (ld_pitch),
    .ld_cnt     (ld_cnt),
    .ld_div     (ld_div),
    .ld_row     (ld_row),
    .ld_start   (ld_start),
    .cur_valid  (cur_valid),
    .cur_ready  (cur_ready),
    .cur_hi     (cur_hi),
    .cur_data   (cur_data),
    .cur_pend   (cur_pend)
  );

  hostif_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (took),
    .busy_t (busy_t)
  );

  hostif_fetch u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig        (ev_dat_rd & ~busy & (cmd_q == CMD_MEM_RD)),
    .fetch_valid (fetch_valid),
    .fetch_ready (fetch_ready),
    .rsp_valid   (fetch_rsp_valid),
    .rsp_data    (fetch_rsp_data),
    .rdbuf       (rdbuf),
    .pend        (fetch_pend)
  );

  assign disp_on     = mode[5];
  assign master_sel  = mode[4];
  assign cursor_mode = mode[3:2];
  assign graphic_sel = mode[1];
  assign ext_cg_sel  = mode[0];

  assign host_dout = sel_status ? {busy, 7'b0} : rdbuf;

endmodule

// File: rtl/lcd_host_if_chk.sv
module lcd_host_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       ld_mode,
  input logic       ld_pitch,
  input logic       ld_cnt,
  input logic       ld_div,
  input logic       ld_row,
  input logic       ld_start,
  input logic [5:0] mode_bits,
  input logic [2:0] pitch_h,
  input logic       cur_valid,
  input logic       cur_ready,
  input logic       cur_hi,
  input logic [7:0] cur_data,
  input logic       fetch_valid,
  input logic       fetch_ready
);

  // R2
  load_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_mode, ld_pitch, ld_cnt, ld_div, ld_row, ld_start}));

  // R2
  load_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_mode | ld_pitch | ld_cnt | ld_div | ld_row | ld_start) |=>
    !(ld_mode | ld_pitch | ld_cnt | ld_div | ld_row | ld_start));

  // R6
  busy_with_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_mode | ld_pitch | ld_cnt | ld_div | ld_row | ld_start) |-> busy);

  // R7
  mode_only_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_bits) |-> ld_mode);

  // R8
  hpitch_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pitch_h >= 3'd5);

  // R11
  cur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_valid && !cur_ready) |=> (cur_valid && $stable(cur_data) && $stable(cur_hi)));

  // R11
  cur_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_valid |-> busy);

  // R12
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready) |=> fetch_valid);

  // R12
  fetch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> busy);

endmodule

bind lcd_host_if lcd_host_if_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .ld_mode     (ld_mode),
  .ld_pitch    (ld_pitch),
  .ld_cnt      (ld_cnt),
  .ld_div      (ld_div),
  .ld_row      (ld_row),
  .ld_start    (ld_start),
  .mode_bits   (mode),
  .pitch_h     (pitch_h),
  .cur_valid   (cur_valid),
  .cur_ready   (cur_ready),
  .cur_hi      (cur_hi),
  .cur_data    (cur_data),
  .fetch_valid (fetch_valid),
  .fetch_ready (fetch_ready)
);

// File: tb/lcd_host_if_test.sv
module lcd_host_if_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       cs_n = 1'b1, rw = 1'b1, rs = 1'b0, en = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       doe;
  logic       disp_on, master_sel, graphic_sel, ext_cg_sel;
  logic [1:0] cursor_mode;
  logic [3:0] pitch_v;
  logic [2:0] pitch_h;
  logic [6:0] char_cnt, time_div;
  logic [3:0] cursor_row;
  logic [15:0] start_addr;
  logic ld_mode, ld_pitch, ld_cnt, ld_div, ld_row, ld_start;
  logic cur_valid, cur_hi;
  logic cur_ready = 1'b1;
  logic [7:0] cur_data;
  logic fetch_valid;
  logic fetch_ready = 1'b1;
  logic rsp_v = 1'b0;
  logic [7:0] rsp_d = 8'h00;

  lcd_host_if uut (
    .clk(clk), .rst_n(rst_n), .host_cs_n(cs_n), .host_rw(rw), .host_rs(rs),
    .host_en(en), .host_din(din), .host_dout(dout), .host_doe(doe),
    .disp_on(disp_on), .master_sel(master_sel), .cursor_mode(cursor_mode),
    .graphic_sel(graphic_sel), .ext_cg_sel(ext_cg_sel), .pitch_v(pitch_v),
    .pitch_h(pitch_h), .char_cnt(char_cnt), .time_div(time_div),
    .cursor_row(cursor_row), .start_addr(start_addr), .ld_mode(ld_mode),
    .ld_pitch(ld_pitch), .ld_cnt(ld_cnt), .ld_div(ld_div), .ld_row(ld_row),
    .ld_start(ld_start), .cur_valid(cur_valid), .cur_ready(cur_ready),
    .cur_hi(cur_hi), .cur_data(cur_data), .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready), .fetch_rsp_valid(rsp_v), .fetch_rsp_data(rsp_d)
  );

  int checks = 0;
  int fails  = 0;
  int ld_total = 0;
  int nfetch = 0;
  logic       last_cur_hi = 1'b0;
  logic [7:0] last_cur_data = 8'h00;

  // memory model: answers one cycle after an accepted request
  always @(posedge clk) begin
    rsp_v <= fetch_valid && fetch_ready;
    if (fetch_valid && fetch_ready) begin
      rsp_d  <= 8'hA0 + 8'(nfetch);
      nfetch <= nfetch + 1;
    end
    ld_total <= ld_total + $countones({ld_mode, ld_pitch, ld_cnt, ld_div, ld_row, ld_start});
    if (cur_valid && cur_ready) begin
      last_cur_hi   <= cur_hi;
      last_cur_data <= cur_data;
    end
  end

  task automatic check(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic sel, input logic [7:0] d, input logic csn = 1'b0);
    @(negedge clk);
    cs_n = csn; rw = 1'b0; rs = sel; din = d; en = 1'b1;
    @(negedge clk);
    check(!doe, "R3 no drive on write", {15'b0, doe}, 16'h0);
    en = 1'b0;
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic bus_read(input logic sel, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b1; rs = sel; en = 1'b1;
    @(negedge clk);
    d = dout;
    if (!doe) d = 8'hxx;
    en = 1'b0;
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 2000; i++) begin
      bus_read(1'b1, s);
      if (s[7] == 1'b0) return;
    end
    check(1'b0, "R6 busy never cleared", 16'h1, 16'h0);
  endtask

  function automatic logic [15:0] field(input logic [3:0] sel);
    case (sel)
      4'd0: return {10'b0, disp_on, master_sel, cursor_mode, graphic_sel, ext_cg_sel};
      4'd1: return {9'b0, pitch_v, pitch_h};
      4'd2: return {9'b0, char_cnt};
      4'd3: return {9'b0, time_div};
      4'd4: return {12'b0, cursor_row};
      default: return start_addr;
    endcase
  endfunction

  // {command byte, parameter byte, field select, expected field}
  localparam logic [35:0] VEC [10] = '{
    {8'h00, 8'h2F, 4'd0, 16'h002F},   // R7 display on, blink cursor, graphic, ext CG
    {8'h00, 8'hD6, 4'd0, 16'h0016},   // R7 master, cursor on, bits 7:6 dropped
    {8'h01, 8'h77, 4'd1, 16'h003F},   // R8 pitch 8x8
    {8'h01, 8'hA6, 4'd1, 16'h0056},   // R8 pitch v=A h=6
    {8'h02, 8'h9F, 4'd2, 16'h001F},   // R10 count 7 bits
    {8'h03, 8'h7F, 4'd3, 16'h007F},   // R10 time divisions
    {8'h04, 8'hF5, 4'd4, 16'h0005},   // R10 cursor row 4 bits
    {8'h08, 8'h3C, 4'd5, 16'h003C},   // R10 start low
    {8'h09, 8'hB2, 4'd5, 16'hB23C},   // R10 start high
    {8'hF2, 8'h42, 4'd2, 16'h0042}    // R4 upper command bits ignored
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int ld0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check({disp_on, master_sel} == 2'b00, "R9 display off slave", {14'b0, disp_on, master_sel}, 16'h0);
    check(pitch_h == 3'd5, "R9 hpitch code", {13'b0, pitch_h}, 16'h5);
    check(!cur_valid && !fetch_valid, "R9 no handshake", {14'b0, cur_valid, fetch_valid}, 16'h0);
    check(!doe, "R3 idle no drive", {15'b0, doe}, 16'h0);
    bus_read(1'b1, r);
    check(r == 8'h00, "R9 R5 not busy after reset", {8'b0, r}, 16'h0);

    // table walk
    for (int i = 0; i < 10; i++) begin
      ld0 = ld_total;
      bus_write(1'b1, VEC[i][35:28]);
      bus_write(1'b0, VEC[i][27:20]);
      bus_read(1'b1, r);
      check(r == 8'h80, "R5 R6 busy after write", {8'b0, r}, 16'h80);
      wait_idle();
      check(field(VEC[i][19:16]) == VEC[i][15:0], "R4 R7 R8 R10 field value",
            field(VEC[i][19:16]), VEC[i][15:0]);
      check(ld_total - ld0 == 1, "R2 one load pulse", 16'(ld_total - ld0), 16'h1);
    end

    // R1 deselected write ignored: command still 2
    bus_write(1'b0, 8'h11, 1'b1);
    bus_read(1'b1, r);
    check(char_cnt == 7'h42 && r == 8'h00, "R1 cs_n high ignored", {9'b0, char_cnt}, 16'h42);

    // R6 command and parameter during busy ignored
    bus_write(1'b1, 8'h00);
    bus_write(1'b0, 8'h20);
    bus_write(1'b1, 8'h03);
    bus_write(1'b0, 8'h11);
    wait_idle();
    check(time_div == 7'h7F, "R6 busy write ignored", {9'b0, time_div}, 16'h7F);
    bus_write(1'b0, 8'h31);
    wait_idle();
    check(field(4'd0) == 16'h0031, "R6 command held during busy", field(4'd0), 16'h31);

    // R8 invalid horizontal pitch ignored, no busy
    bus_write(1'b1, 8'h01);
    ld0 = ld_total;
    bus_write(1'b0, 8'h33);
    bus_read(1'b1, r);
    check(r == 8'h00, "R8 invalid pitch no busy", {8'b0, r}, 16'h0);
    check(field(4'd1) == 16'h0056 && ld_total == ld0, "R8 invalid pitch unchanged", field(4'd1), 16'h56);

    // R13 undefined code ignored
    bus_write(1'b1, 8'h05);
    ld0 = ld_total;
    bus_write(1'b0, 8'hFF);
    bus_read(1'b1, r);
    check(r == 8'h00 && ld_total == ld0, "R13 undefined code", {8'b0, r}, 16'h0);
    check(field(4'd0) == 16'h0031 && char_cnt == 7'h42, "R13 regs unchanged", field(4'd0), 16'h31);

    // R11 cursor handshake with back-pressure
    cur_ready = 1'b0;
    bus_write(1'b1, 8'h0A);
    bus_write(1'b0, 8'h34);
    repeat (300) @(negedge clk);
    check(cur_valid && !cur_hi && cur_data == 8'h34, "R11 cursor low held", {7'b0, cur_valid, cur_data}, 16'h0134);
    bus_read(1'b1, r);
    check(r == 8'h80, "R11 busy while pending", {8'b0, r}, 16'h80);
    cur_ready = 1'b1;
    @(negedge clk);
    check(!cur_valid, "R11 released on ready", {15'b0, cur_valid}, 16'h0);
    wait_idle();
    bus_write(1'b1, 8'h0B);
    bus_write(1'b0, 8'h12);
    wait_idle();
    check(last_cur_hi && last_cur_data == 8'h12, "R11 cursor high byte", {7'b0, last_cur_hi, last_cur_data}, 16'h0112);

    // R12 prefetch read
    bus_write(1'b1, 8'h0D);
    bus_read(1'b0, r);
    check(r == 8'h00, "R12 first read stale", {8'b0, r}, 16'h00);
    wait_idle();
    bus_read(1'b0, r);
    check(r == 8'hA0, "R12 second read", {8'b0, r}, 16'hA0);
    wait_idle();
    bus_read(1'b0, r);
    check(r == 8'hA1, "R12 third read", {8'b0, r}, 16'hA1);
    wait_idle();
    fetch_ready = 1'b0;
    bus_read(1'b0, r);
    check(r == 8'hA2, "R12 fourth read", {8'b0, r}, 16'hA2);
    repeat (5) @(negedge clk);
    bus_read(1'b1, r);
    check(r == 8'h80 && fetch_valid, "R12 busy while fetching", {8'b0, r}, 16'h80);
    fetch_ready = 1'b1;
    wait_idle();
    bus_read(1'b0, r);
    check(r == 8'hA3, "R12 read after stall", {8'b0, r}, 16'hA3);
    wait_idle();

    // R13 parameter write under read command ignored
    ld0 = ld_total;
    bus_write(1'b0, 8'h55);
    bus_read(1'b1, r);
    check(r == 8'h00 && ld_total == ld0, "R13 write under read command", {8'b0, r}, 16'h0);

    // R3 drive only during host read strobe
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b1; rs = 1'b1; en = 1'b0;
    @(negedge clk);
    check(!doe, "R3 strobe low no drive", {15'b0, doe}, 16'h0);
    en = 1'b1;
    @(negedge clk);
    check(doe, "R3 strobe high drives", {15'b0, doe}, 16'h1);
    en = 1'b0;
    @(negedge clk);
    cs_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule